// File: doc/BRIEF.md
# Linked-List Sharer Directory

This block tracks which caches share each memory block without a presence bit vector. Each block holds a single head pointer, and every sharer holds a next and a previous pointer. Together these form a doubly linked chain of the caches that hold a copy. The block keeps the head table and the per-node pointer pairs for a set of blocks. It applies one list command at a time.

A JOIN command adds a node to the front of a block's chain. A LEAVE command splices a node out, as happens when a line is replaced. An EXCL command grants exclusive ownership. It steps through the chain one node per transfer, presents each other sharer on an invalidation output, and then leaves the requester as the only member. A probe port reads back a block's head and a node's pointers without side effects. The surrounding protocol engine uses the probe port, and so does the bench.

Top module: `linked_sharer_dir`

## Requirements
- R1: After reset every chain is empty (head and all pointers invalid), `cmd_ready` is 1, and `inv_valid` and `done` are 0.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from the next cycle until the command has finished, so only one list operation is in flight. Op codes are 0 JOIN, 1 LEAVE, 2 EXCL and 3 no-op.
- R3: JOIN puts the node at the front of the chain. The node's next pointer becomes the old head (invalid if the chain was empty), its previous pointer becomes invalid, the old head's previous pointer becomes the node, and the head becomes the node.
- R4: JOIN of a node that is already in the chain changes no pointer.
- R5: LEAVE of an inner node links its previous node's next pointer to its next node, and links its next node's previous pointer back to its previous node. The leaving node's own pointers become invalid.
- R6: LEAVE of the head moves the head to the head's next node and makes that node's previous pointer invalid. LEAVE of the tail makes the new tail's next pointer invalid. LEAVE of the only member empties the chain.
- R7: LEAVE of a node that is not in the chain changes no pointer.
- R8: EXCL presents every member other than the requester on `inv_node`, in chain order from head to tail, one per transfer (`inv_valid` and `inv_ready` both 1). If the chain holds nobody else, nothing is presented.
- R9: While `inv_valid` is 1 and `inv_ready` is 0, `inv_valid` stays 1 and `inv_node` holds its value.
- R10: When EXCL finishes, the head is the requester and the requester's pointers are invalid. Every invalidated node has invalid pointers. This holds whether or not the requester was in the chain.
- R11: Commands on one block leave every other block's head and pointers unchanged.
- R12: Each accepted command, the no-op included, produces a `done` pulse one cycle wide. The no-op changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 JOIN, 1 LEAVE, 2 EXCL, 3 no-op |
| cmd_blk | input | BLK_W (3) | Block index |
| cmd_node | input | 6 | Acting node (joiner, leaver or requester) |
| inv_valid | output | 1 | Invalidation target presented |
| inv_ready | input | 1 | Invalidation target accepted |
| inv_node | output | 6 | Node to invalidate |
| done | output | 1 | One-cycle pulse at end of a command |
| probe_blk | input | BLK_W (3) | Block to read back |
| probe_node | input | 6 | Node whose pointers are read back |
| probe_head_vld | output | 1 | Head pointer valid |
| probe_head | output | 6 | Head node |
| probe_next_vld | output | 1 | Node's next pointer valid |
| probe_next | output | 6 | Node's next pointer |
| probe_prev_vld | output | 1 | Node's previous pointer valid |
| probe_prev | output | 6 | Node's previous pointer |

## Verification
One block is built up to a three-member chain, so insertion at the front is checked against more than one prior head. Removals are then applied to an inner node, the head, the tail and a node that is not a member. These four patterns separate a correct splice from one that repairs only one side or forgets to move the head. Duplicate joins and work on a second block show that untouched state stays put. Exclusive requests run on a four-member chain with the requester in the middle and with the outlet stalled, and on an empty chain. These show the head-to-tail order, that the requester is skipped, that the output holds under stall, and that the end state is a single-member chain.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    localparam int ID_W     = 6;
    localparam int NODES    = 1 << ID_W;
    localparam int WR_PORTS = 3;

    typedef logic [ID_W-1:0] node_t;

    typedef struct packed {
        logic  vld;
        node_t id;
    } ptr_t;

    typedef struct packed {
        ptr_t nxt;
        ptr_t prv;
    } link_t;

    typedef enum logic [1:0] {
        OP_JOIN  = 2'd0,
        OP_LEAVE = 2'd1,
        OP_EXCL  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_WALK = 2'd2
    } st_e;

    function automatic ptr_t ptr_null();
        return '{vld: 1'b0, id: '0};
    endfunction

    function automatic ptr_t ptr_to(node_t n);
        return '{vld: 1'b1, id: n};
    endfunction

endpackage

// File: rtl/lsd_head_table.sv
module lsd_head_table
    import lsd_pkg::*;
#(
    parameter int BLOCKS = 8,
    parameter int BLK_W  = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BLK_W-1:0] rd_a_blk,
    output ptr_t             rd_a,
    input  logic [BLK_W-1:0] rd_b_blk,
    output ptr_t             rd_b,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_blk,
    input  ptr_t             wr_val
);

    ptr_t head_q [BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BLOCKS; b++) begin
                head_q[b] <= ptr_null();
            end
        end else if (wr_en) begin
            head_q[wr_blk] <= wr_val;
        end
    end

    assign rd_a = head_q[rd_a_blk];
    assign rd_b = head_q[rd_b_blk];

endmodule

// File: rtl/lsd_link_store.sv
module lsd_link_store
    import lsd_pkg::*;
#(
    parameter int BLOCKS = 8,
    parameter int BLK_W  = $clog2(BLOCKS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BLK_W-1:0]    wr_blk,
    input  logic [WR_PORTS-1:0] wr_nxt_en,
    input  logic [WR_PORTS-1:0] wr_prv_en,
    input  node_t               wr_node [WR_PORTS],
    input  ptr_t                wr_nxt  [WR_PORTS],
    input  ptr_t                wr_prv  [WR_PORTS],
    input  logic [BLK_W-1:0]    ra_blk,
    input  node_t               ra_node,
    output link_t               ra,
    input  logic [BLK_W-1:0]    rb_blk,
    input  node_t               rb_node,
    output link_t               rb
);

    localparam int IDX_W = BLK_W + ID_W;
    localparam int DEPTH = 1 << IDX_W;

    link_t            mem_q  [DEPTH];
    logic [IDX_W-1:0] wr_idx [WR_PORTS];

    for (genvar p = 0; p < WR_PORTS; p++) begin : g_wr_idx
        assign wr_idx[p] = {wr_blk, wr_node[p]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int p = 0; p < WR_PORTS; p++) begin
                if (wr_nxt_en[p]) mem_q[wr_idx[p]].nxt <= wr_nxt[p];
                if (wr_prv_en[p]) mem_q[wr_idx[p]].prv <= wr_prv[p];
            end
        end
    end

    assign ra = mem_q[{ra_blk, ra_node}];
    assign rb = mem_q[{rb_blk, rb_node}];

endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
    import lsd_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [BLK_W-1:0]    cmd_blk,
    input  node_t               cmd_node,
    output logic                inv_valid,
    input  logic                inv_ready,
    output node_t               inv_node,
    output logic                done,
    output logic [BLK_W-1:0]    op_blk,
    output node_t               link_rd_node,
    input  ptr_t                head_rd,
    input  link_t               link_rd,
    output logic                head_we,
    output ptr_t                head_val,
    output logic [WR_PORTS-1:0] wr_nxt_en,
    output logic [WR_PORTS-1:0] wr_prv_en,
    output node_t               wr_node [WR_PORTS],
    output ptr_t                wr_nxt  [WR_PORTS],
    output ptr_t                wr_prv  [WR_PORTS]
);

    st_e              state_q, state_d;
    op_e              op_q;
    logic [BLK_W-1:0] blk_q;
    node_t            node_q;
    ptr_t             cur_q, cur_d;
    logic             done_q, done_d;
    logic             member;

    assign cmd_ready    = (state_q == ST_IDLE);
    assign inv_valid    = (state_q == ST_WALK) && cur_q.vld && (cur_q.id != node_q);
    assign inv_node     = cur_q.id;
    assign done         = done_q;
    assign op_blk       = blk_q;
    assign link_rd_node = (state_q == ST_WALK) ? cur_q.id : node_q;

    // A node belongs to the chain if it is the head or has a predecessor.
    assign member = (head_rd.vld && (head_rd.id == node_q)) || link_rd.prv.vld;

    always_comb begin
        state_d   = state_q;
        cur_d     = cur_q;
        done_d    = 1'b0;
        head_we   = 1'b0;
        head_val  = ptr_null();
        wr_nxt_en = '0;
        wr_prv_en = '0;
        for (int p = 0; p < WR_PORTS; p++) begin
            wr_node[p] = '0;
            wr_nxt[p]  = ptr_null();
            wr_prv[p]  = ptr_null();
        end

        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) state_d = ST_EXEC;
            end
            ST_EXEC: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
                case (op_q)
                    OP_JOIN: begin
                        if (!member) begin
                            head_we      = 1'b1;
                            head_val     = ptr_to(node_q);
                            wr_node[0]   = head_rd.id;
                            wr_prv_en[0] = head_rd.vld;
                            wr_prv[0]    = ptr_to(node_q);
                            wr_node[2]   = node_q;
                            wr_nxt_en[2] = 1'b1;
                            wr_prv_en[2] = 1'b1;
                            wr_nxt[2]    = head_rd;
                        end
                    end
                    OP_LEAVE: begin
                        if (member) begin
                            wr_node[0]   = link_rd.prv.id;
                            wr_nxt_en[0] = link_rd.prv.vld;
                            wr_nxt[0]    = link_rd.nxt;
                            wr_node[1]   = link_rd.nxt.id;
                            wr_prv_en[1] = link_rd.nxt.vld;
                            wr_prv[1]    = link_rd.prv;
                            wr_node[2]   = node_q;
                            wr_nxt_en[2] = 1'b1;
                            wr_prv_en[2] = 1'b1;
                            head_we      = !link_rd.prv.vld;
                            head_val     = link_rd.nxt;
                        end
                    end
                    OP_EXCL: begin
                        cur_d   = head_rd;
                        state_d = ST_WALK;
                        done_d  = 1'b0;
                    end
                    default: ;
                endcase
            end
            ST_WALK: begin
                if (!cur_q.vld) begin
                    head_we      = 1'b1;
                    head_val     = ptr_to(node_q);
                    wr_node[2]   = node_q;
                    wr_nxt_en[2] = 1'b1;
                    wr_prv_en[2] = 1'b1;
                    state_d      = ST_IDLE;
                    done_d       = 1'b1;
                end else if (cur_q.id == node_q) begin
                    cur_d = link_rd.nxt;
                end else if (inv_ready) begin
                    cur_d        = link_rd.nxt;
                    wr_node[0]   = cur_q.id;
                    wr_nxt_en[0] = 1'b1;
                    wr_prv_en[0] = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            blk_q   <= '0;
            node_q  <= '0;
            cur_q   <= ptr_null();
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            done_q  <= done_d;
            if (cmd_valid && cmd_ready) begin
                op_q   <= op_e'(cmd_op);
                blk_q  <= cmd_blk;
                node_q <= cmd_node;
            end
        end
    end

endmodule

// File: rtl/linked_sharer_dir.sv
module linked_sharer_dir
    import lsd_pkg::*;
#(
    parameter int BLOCKS = 8,
    parameter int BLK_W  = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic [ID_W-1:0]  cmd_node,
    output logic             inv_valid,
    input  logic             inv_ready,
    output logic [ID_W-1:0]  inv_node,
    output logic             done,
    input  logic [BLK_W-1:0] probe_blk,
    input  logic [ID_W-1:0]  probe_node,
    output logic             probe_head_vld,
    output logic [ID_W-1:0]  probe_head,
    output logic             probe_next_vld,
    output logic [ID_W-1:0]  probe_next,
    output logic             probe_prev_vld,
    output logic [ID_W-1:0]  probe_prev
);

    logic [BLK_W-1:0]    op_blk;
    node_t               link_rd_node;
    ptr_t                head_rd, head_pb, head_val;
    link_t               link_rd, link_pb;
    logic                head_we;
    logic [WR_PORTS-1:0] wr_nxt_en, wr_prv_en;
    node_t               wr_node [WR_PORTS];
    ptr_t                wr_nxt  [WR_PORTS];
    ptr_t                wr_prv  [WR_PORTS];

    lsd_ctrl #(.BLK_W(BLK_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (cmd_op),
        .cmd_blk      (cmd_blk),
        .cmd_node     (cmd_node),
        .inv_valid    (inv_valid),
        .inv_ready    (inv_ready),
        .inv_node     (inv_node),
        .done         (done),
        .op_blk       (op_blk),
        .link_rd_node (link_rd_node),
        .head_rd      (head_rd),
        .link_rd      (link_rd),
        .head_we      (head_we),
        .head_val     (head_val),
        .wr_nxt_en    (wr_nxt_en),
        .wr_prv_en    (wr_prv_en),
        .wr_node      (wr_node),
        .wr_nxt       (wr_nxt),
        .wr_prv       (wr_prv)
    );

    lsd_head_table #(.BLOCKS(BLOCKS), .BLK_W(BLK_W)) u_heads (
        .clk      (clk),
        .rst      (rst),
        .rd_a_blk (op_blk),
        .rd_a     (head_rd),
        .rd_b_blk (probe_blk),
        .rd_b     (head_pb),
        .wr_en    (head_we),
        .wr_blk   (op_blk),
        .wr_val   (head_val)
    );

    lsd_link_store #(.BLOCKS(BLOCKS), .BLK_W(BLK_W)) u_links (
        .clk       (clk),
        .rst       (rst),
        .wr_blk    (op_blk),
        .wr_nxt_en (wr_nxt_en),
        .wr_prv_en (wr_prv_en),
        .wr_node   (wr_node),
        .wr_nxt    (wr_nxt),
        .wr_prv    (wr_prv),
        .ra_blk    (op_blk),
        .ra_node   (link_rd_node),
        .ra        (link_rd),
        .rb_blk    (probe_blk),
        .rb_node   (probe_node),
        .rb        (link_pb)
    );

    assign probe_head_vld = head_pb.vld;
    assign probe_head     = head_pb.id;
    assign probe_next_vld = link_pb.nxt.vld;
    assign probe_next     = link_pb.nxt.id;
    assign probe_prev_vld = link_pb.prv.vld;
    assign probe_prev     = link_pb.prv.id;

endmodule

// File: rtl/lsd_checker.sv
module lsd_checker
    import lsd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            inv_valid,
    input logic            inv_ready,
    input logic [ID_W-1:0] inv_node,
    input logic            done
);

    // R2
    one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2
    walk_blocks_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !cmd_ready);

    // R9
    inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmd_ready && !inv_valid));

endmodule

bind linked_sharer_dir lsd_checker u_lsd_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .inv_valid (inv_valid),
    .inv_ready (inv_ready),
    .inv_node  (inv_node),
    .done      (done)
);

// File: tb/linked_sharer_dir_bench.sv
module linked_sharer_dir_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BLK_W      = 3;
    localparam int ID_W       = 6;
    localparam int NVEC       = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [1:0]       cmd_op = '0;
    logic [BLK_W-1:0] cmd_blk = '0;
    logic [ID_W-1:0]  cmd_node = '0;
    logic             inv_valid;
    logic             inv_ready = 1'b1;
    logic [ID_W-1:0]  inv_node;
    logic             done;
    logic [BLK_W-1:0] probe_blk = '0;
    logic [ID_W-1:0]  probe_node = '0;
    logic             probe_head_vld, probe_next_vld, probe_prev_vld;
    logic [ID_W-1:0]  probe_head, probe_next, probe_prev;

    int n_checks = 0;
    int n_fail   = 0;
    int log_cnt  = 0;
    logic [ID_W-1:0] log_q [16];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    linked_sharer_dir u_linked_sharer_dir (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_node(cmd_node),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
        .done(done),
        .probe_blk(probe_blk), .probe_node(probe_node),
        .probe_head_vld(probe_head_vld), .probe_head(probe_head),
        .probe_next_vld(probe_next_vld), .probe_next(probe_next),
        .probe_prev_vld(probe_prev_vld), .probe_prev(probe_prev)
    );

    // Transfer logger, sampled after the negedge drivers have settled.
    always @(negedge clk) begin
        #2;
        if (inv_valid && inv_ready && log_cnt < 16) begin
            log_q[log_cnt] = inv_node;
            log_cnt++;
        end
    end

    typedef struct packed {
        logic [1:0]       op;
        logic [BLK_W-1:0] blk;
        logic [ID_W-1:0]  node;
        logic             hv;
        logic [ID_W-1:0]  hid;
        logic [ID_W-1:0]  pnode;
        logic             nv;
        logic [ID_W-1:0]  nid;
        logic             pv;
        logic [ID_W-1:0]  pid;
    } vec_t;

    // op, blk, node | head vld,id | probe node | next vld,id | prev vld,id
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 3'd2, 6'd5,  1'b1, 6'd5,  6'd5,  1'b0, 6'd0, 1'b0, 6'd0},   // R3 empty join
        '{2'd0, 3'd2, 6'd9,  1'b1, 6'd9,  6'd5,  1'b0, 6'd0, 1'b1, 6'd9},   // R3
        '{2'd0, 3'd2, 6'd20, 1'b1, 6'd20, 6'd9,  1'b1, 6'd5, 1'b1, 6'd20},  // R3
        '{2'd0, 3'd2, 6'd9,  1'b1, 6'd20, 6'd9,  1'b1, 6'd5, 1'b1, 6'd20},  // R4 duplicate
        '{2'd1, 3'd2, 6'd9,  1'b1, 6'd20, 6'd20, 1'b1, 6'd5, 1'b0, 6'd0},   // R5 inner
        '{2'd0, 3'd2, 6'd33, 1'b1, 6'd33, 6'd20, 1'b1, 6'd5, 1'b1, 6'd33},  // R3
        '{2'd1, 3'd2, 6'd33, 1'b1, 6'd20, 6'd33, 1'b0, 6'd0, 1'b0, 6'd0},   // R6 head
        '{2'd1, 3'd2, 6'd40, 1'b1, 6'd20, 6'd5,  1'b0, 6'd0, 1'b1, 6'd20},  // R7 non-member
        '{2'd1, 3'd2, 6'd5,  1'b1, 6'd20, 6'd20, 1'b0, 6'd0, 1'b0, 6'd0},   // R6 tail
        '{2'd0, 3'd3, 6'd7,  1'b1, 6'd7,  6'd7,  1'b0, 6'd0, 1'b0, 6'd0},   // R11 other block
        '{2'd1, 3'd2, 6'd20, 1'b0, 6'd0,  6'd20, 1'b0, 6'd0, 1'b0, 6'd0}    // R6 last member
    };

    function automatic string tag_of(int i);
        case (i)
            3:       return "R4";
            4:       return "R5";
            7:       return "R7";
            9:       return "R11";
            6, 8, 10: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Present a command and wait for it to be taken; ready must drop next cycle.
    task automatic issue(logic [1:0] op, logic [BLK_W-1:0] blk, logic [ID_W-1:0] node);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_blk   = blk;
        cmd_node  = node;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R2", "ready low after accept", {31'd0, cmd_ready}, 32'd0);
    endtask

    task automatic wait_done(string req);
        bit seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
        check(req, "done pulse", {31'd0, seen}, 32'd1);
    endtask

    task automatic probe(logic [BLK_W-1:0] blk, logic [ID_W-1:0] node);
        probe_blk  = blk;
        probe_node = node;
        #1;
    endtask

    task automatic check_links(string req, logic [BLK_W-1:0] blk, logic [ID_W-1:0] node,
                               logic nv, logic [ID_W-1:0] nid, logic pv, logic [ID_W-1:0] pid);
        probe(blk, node);
        check(req, "next ptr", {25'd0, probe_next_vld, probe_next}, {25'd0, nv, nid});
        check(req, "prev ptr", {25'd0, probe_prev_vld, probe_prev}, {25'd0, pv, pid});
    endtask

    task automatic check_head(string req, logic [BLK_W-1:0] blk, logic hv, logic [ID_W-1:0] hid);
        probe(blk, 6'd0);
        check(req, "head ptr", {25'd0, probe_head_vld, probe_head}, {25'd0, hv, hid});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "ready", {31'd0, cmd_ready}, 32'd1);
        check("R1", "inv_valid", {31'd0, inv_valid}, 32'd0);
        check("R1", "done", {31'd0, done}, 32'd0);
        check_head("R1", 3'd0, 1'b0, 6'd0);
        check_links("R1", 3'd5, 6'd63, 1'b0, 6'd0, 1'b0, 6'd0);

        // Table of list edits on blocks 2 and 3
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].op, VEC[i].blk, VEC[i].node);
            wait_done("R12");
            check_head(tag_of(i), VEC[i].blk, VEC[i].hv, VEC[i].hid);
            check_links(tag_of(i), VEC[i].blk, VEC[i].pnode,
                        VEC[i].nv, VEC[i].nid, VEC[i].pv, VEC[i].pid);
        end
        // R11 block 3 untouched by the final block 2 edit
        check_head("R11", 3'd3, 1'b1, 6'd7);

        // EXCL on block 1: chain 13,12,11,10, requester 11, outlet stalled
        issue(2'd0, 3'd1, 6'd10); wait_done("R12");
        issue(2'd0, 3'd1, 6'd11); wait_done("R12");
        issue(2'd0, 3'd1, 6'd12); wait_done("R12");
        issue(2'd0, 3'd1, 6'd13); wait_done("R12");
        inv_ready = 1'b0;
        log_cnt   = 0;
        issue(2'd2, 3'd1, 6'd11);
        @(negedge clk);
        check("R8", "first target valid", {31'd0, inv_valid}, 32'd1);
        check("R8", "first target node", {26'd0, inv_node}, {26'd0, 6'd13});
        @(negedge clk);
        check("R9", "held valid", {31'd0, inv_valid}, 32'd1);
        check("R9", "held node", {26'd0, inv_node}, {26'd0, 6'd13});
        check("R2", "ready low in walk", {31'd0, cmd_ready}, 32'd0);
        inv_ready = 1'b1;
        wait_done("R10");
        check("R8", "target count", log_cnt, 32'd3);
        check("R8", "target 0", {26'd0, log_q[0]}, {26'd0, 6'd13});
        check("R8", "target 1", {26'd0, log_q[1]}, {26'd0, 6'd12});
        check("R8", "target 2", {26'd0, log_q[2]}, {26'd0, 6'd10});
        check_head("R10", 3'd1, 1'b1, 6'd11);
        check_links("R10", 3'd1, 6'd11, 1'b0, 6'd0, 1'b0, 6'd0);
        check_links("R10", 3'd1, 6'd13, 1'b0, 6'd0, 1'b0, 6'd0);
        check_links("R10", 3'd1, 6'd10, 1'b0, 6'd0, 1'b0, 6'd0);

        // R8 / R10 EXCL on an empty chain
        log_cnt = 0;
        issue(2'd2, 3'd4, 6'd3);
        wait_done("R10");
        check("R8", "no targets on empty", log_cnt, 32'd0);
        check_head("R10", 3'd4, 1'b1, 6'd3);

        // R12 no-op leaves block 1 intact
        issue(2'd3, 3'd1, 6'd5);
        wait_done("R12");
        check_head("R12", 3'd1, 1'b1, 6'd11);
        check_links("R12", 3'd1, 6'd5, 1'b0, 6'd0, 1'b0, 6'd0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule